// File: doc/BRIEF.md
# Serial Control and Status Shift Port

This block is a synchronous serial slave that lives in the system clock domain of a load-switch controller. An external host frames a transfer by pulling an active-low select line, then clocks a 16-bit control word into the block, least significant bit first, while the block returns a 16-bit status word on its data output at the same time. The status word is captured from the protection logic at the moment the select line falls. The control word is handed to the protection and switch logic only when the select line returns high after exactly sixteen serial clock pulses.

The serial select, clock and data inputs are asynchronous to the system clock. Each passes through a synchronizer, and all framing decisions are made from edges detected on the synchronized copies. The serial clock therefore has to stay at least four system clocks in each phase. A host may also pull select low, read the temperature-warning status bit that appears on the output at once, and release select with no clock pulses. Such a short frame leaves the control register untouched.

Bit 0 of a committed control word is not stored. A one there produces a single-cycle clear request to the status logic.

Top module: `ser_ctrl_port`

## Requirements
- R1: After reset the control register reads 16'hE000: bits 15, 14 and 13 are one and all other bits are zero. The output enable is low and no clear request is raised.
- R2: The word is sampled from the data input on falling serial-clock edges, least significant bit first. The n-th falling edge after select falls supplies bit n-1.
- R3: The output enable is low while select is high and high from the select falling edge until the select rising edge. The data output is held at zero whenever the enable is low. Each select edge takes effect within three system clocks of the pin change.
- R4: Status is captured when select falls, and its bit 0 is driven at once. After the k-th rising serial-clock edge that follows at least one falling edge, bit k is driven. After bit 15 the output shows zero. Changes on the status input during a frame do not affect the bits shifted out.
- R5: The control register changes only in response to a select rising edge. Serial-clock activity while select is high has no effect.
- R6: A word is committed only if exactly 16 falling serial-clock edges were seen since select fell. With 0, 15 or 17 edges the register keeps its value and no clear request is raised.
- R7: A committed word is stored with bit 0 forced to zero. Bits 15 to 1 are stored as received. The consumer decodes bit 13 as open-load detection (active low), bit 14 as the delay choice and bit 15 as run (one = run). Bits 1 to 6 are the switch enables.
- R8: When a committed word has bit 0 set, the clear request is high for exactly one system clock. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_ni | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles low, asynchronous |
| sdin_i | input | 1 | Serial data in, asynchronous |
| status_i | input | 16 | Status word from the protection logic |
| sdout_o | output | 1 | Serial data out, zero when not enabled |
| sdout_oe_o | output | 1 | Output enable for the data-out pad driver |
| ctrl_o | output | 16 | Committed control register |
| clr_pulse_o | output | 1 | One-cycle status clear request |

## Verification
On every cycle the checker confirms several properties: the control register moves only after a detected select rising edge, and an edge that ends a frame of the wrong length leaves it stable. It also confirms that the output enable follows the detected select edges, that stored bit 0 is zero, and that the clear request is a single-cycle pulse tied to a full-length commit. The bit order on both data lines, the status snapshot taken at frame start, the reset word and the discarding of 0, 15 and 17 pulse frames are shown only by the bench's frames. The bench runs each frame from the pins and compares the results with a model of the word it sent.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int unsigned DEF_FRAME_BITS  = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam logic [15:0] DEF_RESET_WORD  = 16'hE000;
  localparam int unsigned CLR_REQ_BIT     = 0;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scp_edge.sv
module scp_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_fall_i,
  input  logic             sel_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sdin_i,
  input  logic [W-1:0]     status_i,
  output logic [W-1:0]     rx_word_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sdout_o,
  output logic             oe_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             oe_q,  oe_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rx_q,  rx_d;
  logic [W-1:0]     tx_q,  tx_d;

  always_comb begin
    oe_d  = oe_q;
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (sel_fall_i) begin
      oe_d  = 1'b1;
      cnt_d = '0;
      tx_d  = status_i;
    end else if (sel_rise_i) begin
      oe_d  = 1'b0;
    end else if (oe_q) begin
      if (sclk_fall_i) begin
        rx_d = {sdin_i, rx_q[W-1:1]};
        if (cnt_q != CNT_SAT) cnt_d = cnt_q + CNT_ONE;
      end
      if (sclk_rise_i && (cnt_q != '0)) begin
        tx_d = {1'b0, tx_q[W-1:1]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      oe_q  <= oe_d;
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  assign rx_word_o = rx_q;
  assign cnt_o     = cnt_q;
  assign oe_o      = oe_q;
  assign sdout_o   = tx_q[0] & oe_q;
endmodule

// File: rtl/scp_ctrl_reg.sv
module scp_ctrl_reg #(
  parameter int unsigned   W        = 16,
  parameter logic [W-1:0]  RST_WORD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         commit_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] ctrl_o,
  output logic         clr_pulse_o
);
  logic [W-1:0] ctrl_q, ctrl_d;
  logic         pulse_q, pulse_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    pulse_d = 1'b0;
    if (commit_i) begin
      ctrl_d  = {word_i[W-1:1], 1'b0};
      pulse_d = word_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= {RST_WORD[W-1:1], 1'b0};
      pulse_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      pulse_q <= pulse_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign clr_pulse_o = pulse_q;
endmodule

// File: rtl/ser_ctrl_port.sv
module ser_ctrl_port
  import ser_ctrl_pkg::*;
#(
  parameter int unsigned            FRAME_BITS  = DEF_FRAME_BITS,
  parameter int unsigned            SYNC_STAGES = DEF_SYNC_STAGES,
  parameter logic [FRAME_BITS-1:0]  RESET_WORD  = FRAME_BITS'(DEF_RESET_WORD)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_ni,
  input  logic                  sclk_i,
  input  logic                  sdin_i,
  input  logic [FRAME_BITS-1:0] status_i,
  output logic                  sdout_o,
  output logic                  sdout_oe_o,
  output logic [FRAME_BITS-1:0] ctrl_o,
  output logic                  clr_pulse_o
);
  localparam int unsigned      CNT_W    = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic sel_lvl, sclk_lvl, sdin_lvl;
  logic sel_rise, sel_fall, sclk_rise, sclk_fall;
  logic [FRAME_BITS-1:0] rx_word;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  commit;

  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sel_ni), .q_o(sel_lvl));
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_lvl));
  scp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdin_i), .q_o(sdin_lvl));

  scp_edge #(.RST_VAL(1'b1)) u_edge_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sel_lvl),
    .rise_o(sel_rise), .fall_o(sel_fall));
  scp_edge #(.RST_VAL(1'b0)) u_edge_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sclk_lvl),
    .rise_o(sclk_rise), .fall_o(sclk_fall));

  scp_shift #(.W(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_fall_i  (sel_fall),
    .sel_rise_i  (sel_rise),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sdin_i      (sdin_lvl),
    .status_i    (status_i),
    .rx_word_o   (rx_word),
    .cnt_o       (bit_cnt),
    .sdout_o     (sdout_o),
    .oe_o        (sdout_oe_o)
  );

  assign commit = sel_rise & (bit_cnt == CNT_FULL);

  scp_ctrl_reg #(.W(FRAME_BITS), .RST_WORD(RESET_WORD)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .word_i      (rx_word),
    .ctrl_o      (ctrl_o),
    .clr_pulse_o (clr_pulse_o)
  );
endmodule

// File: rtl/ser_ctrl_port_chk.sv
module ser_ctrl_port_chk #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CNT_W      = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sel_rise,
  input logic                  sel_fall,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic                  sdout_o,
  input logic                  sdout_oe_o,
  input logic [FRAME_BITS-1:0] ctrl_o,
  input logic                  clr_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  p_oe_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_fall |=> sdout_oe_o);
  p_oe_off_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rise |=> !sdout_oe_o);
  p_quiet_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdout_oe_o |-> !sdout_o);
  p_ctrl_moves_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(sel_rise));
  p_short_frame_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise && (bit_cnt != CNT_FULL)) |=> ($stable(ctrl_o) && !clr_pulse_o));
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_SAT);
  p_bit0_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0]);
  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse_o |=> !clr_pulse_o);
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse_o |-> ($past(sel_rise) && ($past(bit_cnt) == CNT_FULL)));
endmodule

bind ser_ctrl_port ser_ctrl_port_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_rise    (sel_rise),
  .sel_fall    (sel_fall),
  .bit_cnt     (bit_cnt),
  .sdout_o     (sdout_o),
  .sdout_oe_o  (sdout_oe_o),
  .ctrl_o      (ctrl_o),
  .clr_pulse_o (clr_pulse_o)
);

// File: tb/sim_ser_ctrl_port.sv
module sim_ser_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n, sclk, sdin;
  logic [15:0] status;
  logic        sdout, sdout_oe, clr_pulse;
  logic [15:0] ctrl;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic [15:0] exp_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_ctrl_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .sdin_i(sdin),
    .status_i(status), .sdout_o(sdout), .sdout_oe_o(sdout_oe),
    .ctrl_o(ctrl), .clr_pulse_o(clr_pulse));

  always @(posedge clk) if (rst_n && clr_pulse) pulses <= pulses + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] stored_word(input logic [15:0] w);
    return {w[15:1], 1'b0};
  endfunction

  task automatic frame(input logic [15:0] word, input logic [15:0] stat,
                       input int nbits, input bit disturb);
    int p0;
    p0 = pulses;
    status = stat;
    sel_n = 1'b0;
    wt(HALF);
    chk("R3 enable after select fall", 32'(sdout_oe), 32'd1);
    chk("R4 bit0 at select fall", 32'(sdout), 32'(stat[0]));
    if (disturb) status = ~stat;
    for (int i = 0; i < nbits; i++) begin
      sdin = word[i % 16];
      sclk = 1'b1;
      wt(HALF);
      chk("R4 serial out bit", 32'(sdout), (i < 16) ? 32'(stat[i]) : 32'd0);
      sclk = 1'b0;
      wt(HALF);
    end
    sel_n = 1'b1;
    wt(HALF);
    chk("R3 enable off after select rise", 32'(sdout_oe), 32'd0);
    chk("R3 data low while disabled", 32'(sdout), 32'd0);
    if (nbits == 16) begin
      exp_ctrl = stored_word(word);
      chk("R2 R7 committed word", 32'(ctrl), 32'(exp_ctrl));
      chk("R8 clear pulse count", 32'(pulses - p0), 32'(word[0]));
    end else begin
      chk("R6 wrong-length frame keeps register", 32'(ctrl), 32'(exp_ctrl));
      chk("R6 no clear pulse", 32'(pulses - p0), 32'd0);
    end
    wt(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdin = 1'b0; status = 16'h0;
    wt(5);
    rst_n = 1'b1;
    wt(4);
    exp_ctrl = 16'hE000;
    chk("R1 reset word", 32'(ctrl), 32'hE000);
    chk("R1 enable low", 32'(sdout_oe), 32'd0);
    chk("R1 no pulse", 32'(clr_pulse), 32'd0);

    // short warning read: no clock pulses
    frame(16'h1234, 16'h0001, 0, 1'b0);
    frame(16'h1234, 16'hFFFE, 0, 1'b0);
    // full frames, directed
    frame(16'h007F, 16'hA5C3, 16, 1'b0);
    frame(16'h8000, 16'h5A3C, 16, 1'b1);
    frame(16'hFFFE, 16'hFFFF, 16, 1'b0);
    // length errors
    frame(16'h0F0F, 16'h1357, 15, 1'b0);
    frame(16'h0F0F, 16'h2468, 17, 1'b0);

    // R5: serial clock toggling while deselected is ignored
    for (int k = 0; k < 20; k++) begin
      sdin = k[0]; sclk = ~sclk; wt(HALF);
    end
    sclk = 1'b0; wt(HALF);
    chk("R5 idle clocking ignored", 32'(ctrl), 32'(exp_ctrl));
    chk("R5 enable stays low", 32'(sdout_oe), 32'd0);

    // randomized frames
    for (int n = 0; n < 60; n++) begin
      logic [15:0] w, s;
      int len;
      w = 16'($urandom);
      s = 16'($urandom);
      len = ($urandom % 8 == 0) ? (14 + int'($urandom % 5)) : 16;
      frame(w, s, len, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule